// File: doc/BRIEF.md
# Composite Status Frame Transmitter

This block assembles a 32-bit status frame and sends it on one Manchester-coded serial line. The same line fans out to up to sixteen downstream processing cards. Each frame carries a fixed header and a 16-bit composite word. The composite word holds the 5-bit energy level, an error flag, a soft-reset request, an under-test flag, two beam-info bits, two permit-line test enables and the number of the card that must trip during an internal permit check. After the composite word come a toggle bit, three zero bits and a 4-bit CRC.

A frame-start strobe, normally one per millisecond, captures every field in the same cycle and starts transmission. A separate pulse marks the arrival of a new energy value, and the toggle bit changes on the next frame that follows it. When the upstream link is lost, a fixed safe composite word replaces the live fields. The bit rate comes from the clock frequency and the bit-rate parameters. Between frames the line rests low.

Top module: `status_frame_tx`

## Requirements
- R1: Every frame is 32 bits sent most significant bit first. Bits 31..24 are the header 8'b1001_0000. Bits 23..8 are the composite word. Bit 7 is the toggle bit and bits 6..4 are zero. Bits 3..0 are the CRC.
- R2: Composite word layout, with link_lost low: [15:11] energy level, [10] error flag, [9] soft reset request, [8] under-test flag, [7] unmaskable beam info, [6] maskable beam info, [5] unmaskable permit-line test, [4] maskable permit-line test, [3:0] target card number.
- R3: With link_lost high at the strobe, the composite word is 16'hFCC0 (level 31, error 1, reset 0, test 0, both beam-info bits 1, both test enables 0, card 0), whatever the other field inputs are.
- R4: The toggle bit is 0 after reset. It inverts exactly once at an accepted strobe if at least one level_update pulse came after the previous accepted strobe, counting a pulse in the strobe cycle itself. Otherwise it keeps its value.
- R5: The CRC is the remainder of frame bits 31..4, MSB first, divided by x^4+x+1, with initial value 0 and no final inversion.
- R6: Each bit lasts CLK_HZ/BIT_HZ clock cycles and is split into two equal halves. The first half carries the inverted bit and the second half carries the bit, so a 1 is a low-to-high transition.
- R7: tx_line is low during and after reset and whenever no frame is in flight. The first half of bit 31 starts in the cycle after the clock edge that accepts the strobe.
- R8: All fields, link_lost and the toggle decision are captured at the accepted strobe. Input changes during a frame do not alter that frame.
- R9: A strobe that arrives while a frame is in flight is ignored: the frame is not restarted and no extra frame follows. A level_update pulse in that time still counts toward the next accepted strobe.
- R10: A frame ends after exactly 64 half-bit periods, and the line returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Strobe that captures the fields and starts a frame |
| level_update | input | 1 | Pulse marking that a new energy level was taken over |
| link_lost | input | 1 | Forces the safe composite word |
| energy_level | input | 5 | Energy level 0 to 31 |
| err_flag | input | 1 | Error flag |
| soft_reset_req | input | 1 | Soft reset request to downstream cards |
| under_test | input | 1 | System under test flag |
| binfo_unmask | input | 1 | Unmaskable beam info |
| binfo_mask | input | 1 | Maskable beam info |
| plt_unmask | input | 1 | Unmaskable permit-line test enable |
| plt_mask | input | 1 | Maskable permit-line test enable |
| card_sel | input | 4 | Card that must provoke a dump, 0 to 15 |
| tx_line | output | 1 | Manchester-coded serial output |

## Verification
The bench builds the block with CLK_HZ=8 and BIT_HZ=1, which gives four clock cycles per half bit, so a whole frame takes 256 cycles. Many frames fit in a short run at this setting. Every half-bit can be sampled in its middle, which makes both the mid-bit transition and the exact frame length visible. It also lets a strobe land well inside a frame, and lets level_update pulses arrive between frames, in the strobe cycle and during a frame.

// File: rtl/sft_pkg.sv
`timescale 1ns/1ps
package sft_pkg;

   localparam int FRAME_BITS = 32;
   localparam int CRC_W      = 4;
   localparam int BODY_BITS  = FRAME_BITS - CRC_W;
   localparam int HALVES     = 2 * FRAME_BITS;

   localparam logic [7:0] FRAME_HDR = 8'b1001_0000;

   typedef struct packed {
      logic [4:0] level;
      logic       err;
      logic       soft_rst;
      logic       under_test;
      logic       binfo_u;
      logic       binfo_m;
      logic       plt_u;
      logic       plt_m;
      logic [3:0] card;
   } ctrl_word_t;

   localparam ctrl_word_t SAFE_WORD = '{
      level:      5'd31,
      err:        1'b1,
      soft_rst:   1'b0,
      under_test: 1'b0,
      binfo_u:    1'b1,
      binfo_m:    1'b1,
      plt_u:      1'b0,
      plt_m:      1'b0,
      card:       4'd0
   };

endpackage

// File: rtl/sft_compose.sv
`timescale 1ns/1ps
module sft_compose
   import sft_pkg::*;
(
   input  logic                 link_lost,
   input  ctrl_word_t           live_word,
   input  logic                 toggle_bit,
   output ctrl_word_t           word_out,
   output logic [BODY_BITS-1:0] body
);

   always_comb begin
      if (link_lost) word_out = SAFE_WORD;
      else           word_out = live_word;
   end

   assign body = {FRAME_HDR, word_out, toggle_bit, 3'b000};

endmodule

// File: rtl/sft_crc.sv
`timescale 1ns/1ps
module sft_crc #(
   parameter int           W    = 4,
   parameter int           N    = 28,
   parameter logic [W-1:0] POLY = 4'b0011,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic [N-1:0] data,
   output logic [W-1:0] crc
);

   if (W < 2)        begin : g_bad_w   $error("sft_crc: W must be at least 2");  end
   if (N < 1)        begin : g_bad_n   $error("sft_crc: N must be positive");    end
   if (POLY[0] != 1) begin : g_bad_p   $error("sft_crc: POLY needs a unit term"); end

   for (genvar i = 0; i < N; i++) begin : g_stage
      logic [W-1:0] prev;
      logic [W-1:0] nxt;
      logic         fb;
      if (i == 0) begin : g_first
         assign prev = INIT;
      end else begin : g_next
         assign prev = g_stage[i-1].nxt;
      end
      assign fb  = data[N-1-i] ^ prev[W-1];
      assign nxt = {prev[W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc = g_stage[N-1].nxt;

endmodule

// File: rtl/sft_serializer.sv
`timescale 1ns/1ps
module sft_serializer
   import sft_pkg::*;
#(
   parameter int HALF_CYC   = 20,
   parameter bit ONE_RISING = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [FRAME_BITS-1:0] frame,
   output logic                  busy,
   output logic [5:0]            half_idx,
   output logic                  step,
   output logic                  line
);

   localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);
   localparam logic [5:0]       HALF_LAST = 6'(HALVES - 1);

   if (HALF_CYC < 1) begin : g_bad_half $error("sft_serializer: HALF_CYC must be positive"); end

   logic [DIV_W-1:0]      div_q;
   logic [FRAME_BITS-1:0] sh_q;
   logic                  cur;

   assign step = busy && (div_q == DIV_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         sh_q     <= '0;
         half_idx <= '0;
         div_q    <= '0;
      end else if (load && !busy) begin
         busy     <= 1'b1;
         sh_q     <= frame;
         half_idx <= '0;
         div_q    <= '0;
      end else if (busy) begin
         if (div_q == DIV_LAST) begin
            div_q    <= '0;
            half_idx <= half_idx + 6'd1;
            if (half_idx[0]) sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
            if (half_idx == HALF_LAST) busy <= 1'b0;
         end else begin
            div_q <= div_q + DIV_W'(1);
         end
      end
   end

   if (ONE_RISING) begin : g_rise_one
      assign cur = half_idx[0] ? sh_q[FRAME_BITS-1] : ~sh_q[FRAME_BITS-1];
   end else begin : g_fall_one
      assign cur = half_idx[0] ? ~sh_q[FRAME_BITS-1] : sh_q[FRAME_BITS-1];
   end

   assign line = busy & cur;

endmodule

// File: rtl/status_frame_tx.sv
`timescale 1ns/1ps
module status_frame_tx
   import sft_pkg::*;
#(
   parameter int           CLK_HZ     = 40_000_000,
   parameter int           BIT_HZ     = 1_000_000,
   parameter bit           ONE_RISING = 1'b1,
   parameter logic [3:0]   CRC_POLY   = 4'b0011,
   parameter logic [3:0]   CRC_INIT   = 4'b0000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_start,
   input  logic       level_update,
   input  logic       link_lost,
   input  logic [4:0] energy_level,
   input  logic       err_flag,
   input  logic       soft_reset_req,
   input  logic       under_test,
   input  logic       binfo_unmask,
   input  logic       binfo_mask,
   input  logic       plt_unmask,
   input  logic       plt_mask,
   input  logic [3:0] card_sel,
   output logic       tx_line
);

   localparam int HALF_CYC = CLK_HZ / (2 * BIT_HZ);

   if (BIT_HZ < 1 || CLK_HZ % (2 * BIT_HZ) != 0 || HALF_CYC < 1) begin : g_bad_rate
      $error("status_frame_tx: CLK_HZ must be a positive multiple of 2*BIT_HZ");
   end

   logic       busy;
   logic       accept;
   logic       step;
   logic [5:0] half_idx;
   logic       toggle_q;
   logic       pend_q;
   logic       tog_next;

   ctrl_word_t           live_word;
   ctrl_word_t           word_sel;
   logic [BODY_BITS-1:0] body;
   logic [CRC_W-1:0]     crc;

   assign accept   = frame_start && !busy;
   assign tog_next = toggle_q ^ (pend_q | level_update);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         toggle_q <= 1'b0;
         pend_q   <= 1'b0;
      end else if (accept) begin
         toggle_q <= tog_next;
         pend_q   <= 1'b0;
      end else if (level_update) begin
         pend_q   <= 1'b1;
      end
   end

   assign live_word = '{
      level:      energy_level,
      err:        err_flag,
      soft_rst:   soft_reset_req,
      under_test: under_test,
      binfo_u:    binfo_unmask,
      binfo_m:    binfo_mask,
      plt_u:      plt_unmask,
      plt_m:      plt_mask,
      card:       card_sel
   };

   sft_compose u_compose (
      .link_lost  (link_lost),
      .live_word  (live_word),
      .toggle_bit (tog_next),
      .word_out   (word_sel),
      .body       (body)
   );

   sft_crc #(
      .W    (CRC_W),
      .N    (BODY_BITS),
      .POLY (CRC_POLY),
      .INIT (CRC_INIT)
   ) u_crc (
      .data (body),
      .crc  (crc)
   );

   sft_serializer #(
      .HALF_CYC   (HALF_CYC),
      .ONE_RISING (ONE_RISING)
   ) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .frame    ({body, crc}),
      .busy     (busy),
      .half_idx (half_idx),
      .step     (step),
      .line     (tx_line)
   );

endmodule

// File: rtl/status_frame_tx_chk.sv
`timescale 1ns/1ps
module status_frame_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_start,
   input logic       accept,
   input logic       busy,
   input logic       step,
   input logic [5:0] half_idx,
   input logic       toggle_q,
   input logic       tx_line
);

   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_line);

   a_r7_start_next: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy && half_idx == 6'd0));

   a_r6_mid_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && half_idx[0] && !$past(half_idx[0])) |-> (tx_line != $past(tx_line)));

   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frame_start && !step) |=> (busy && $stable(half_idx)));

   a_r10_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(half_idx) == 6'd63));

   a_r4_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(toggle_q));

endmodule

bind status_frame_tx status_frame_tx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .accept      (accept),
   .busy        (busy),
   .step        (step),
   .half_idx    (half_idx),
   .toggle_q    (toggle_q),
   .tx_line     (tx_line)
);

// File: tb/status_frame_tx_tb.sv
`timescale 1ns/1ps
module status_frame_tx_tb;

   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 0, level_update = 0, link_lost = 0;
   logic [4:0] energy_level = 0;
   logic err_flag = 0, soft_reset_req = 0, under_test = 0;
   logic binfo_unmask = 0, binfo_mask = 0, plt_unmask = 0, plt_mask = 0;
   logic [3:0] card_sel = 0;
   logic tx_line;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic        exp_tog = 1'b0;
   logic        pend = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   event        ev_go;

   always #4 clk = ~clk;

   status_frame_tx #(.CLK_HZ(8), .BIT_HZ(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .level_update(level_update),
      .link_lost(link_lost), .energy_level(energy_level), .err_flag(err_flag),
      .soft_reset_req(soft_reset_req), .under_test(under_test),
      .binfo_unmask(binfo_unmask), .binfo_mask(binfo_mask),
      .plt_unmask(plt_unmask), .plt_mask(plt_mask), .card_sel(card_sel), .tx_line(tx_line)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_crc(input logic [27:0] d);
      logic [31:0] r = {d, 4'b0000};
      for (int i = 31; i >= 4; i--)
         if (r[i]) r[i -: 5] = r[i -: 5] ^ 5'b10011;
      return r[3:0];
   endfunction

   task automatic set_fields(input logic lost, input logic [4:0] lv, input logic [10:0] ctl);
      link_lost = lost; energy_level = lv;
      {err_flag, soft_reset_req, under_test, binfo_unmask, binfo_mask,
       plt_unmask, plt_mask, card_sel} = ctl;
   endtask

   // driver: strobe a frame and push its expected image
   task automatic send(input logic lost, input logic [4:0] lv, input logic [10:0] ctl,
                       input logic upd, input string tag);
      logic [15:0] w;
      logic [27:0] body;
      @(negedge clk);
      set_fields(lost, lv, ctl);
      frame_start = 1'b1;
      level_update = upd;
      @(posedge clk);
      exp_tog = exp_tog ^ (pend | upd);
      pend = 1'b0;
      w = lost ? 16'hFCC0 : {lv, ctl};
      body = {8'h90, w, exp_tog, 3'b000};
      exp_q.push_back({body, ref_crc(body)});
      tag_q.push_back(tag);
      ->ev_go;
      @(negedge clk);
      frame_start = 1'b0;
      level_update = 1'b0;
   endtask

   task automatic pulse_update();
      @(negedge clk);
      level_update = 1'b1;
      @(negedge clk);
      level_update = 1'b0;
      pend = 1'b1;
   endtask

   task automatic wait_done();
      repeat (64 * HALF + 8) @(posedge clk);
      @(negedge clk);
      check(tx_line == 1'b0, "R10", {31'd0, tx_line}, 32'd0);
   endtask

   // monitor: decode 64 half-bits and compare against the scoreboard
   initial begin
      forever begin
         logic [31:0] got;
         logic [31:0] exp;
         string       tag;
         int          bad_halves;
         @(ev_go);
         bad_halves = 0;
         #20;
         for (int b = 31; b >= 0; b--) begin
            logic s0, s1;
            s0 = tx_line;
            #32;
            s1 = tx_line;
            #32;
            if (s0 == s1) bad_halves++;
            got[b] = s1;
         end
         check(bad_halves == 0, "R6", bad_halves, 0);
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", got, 32'd0);
         end else begin
            exp = exp_q.pop_front();
            tag = tag_q.pop_front();
            check(got[31:24] == exp[31:24], "R1", got, exp);
            check(got[23:8] == exp[23:8], tag, got, exp);
            check(got[7:4] == exp[7:4], "R4", got, exp);
            check(got[3:0] == exp[3:0], "R5", got, exp);
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(tx_line == 1'b0, "R7", {31'd0, tx_line}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(tx_line == 1'b0, "R7", {31'd0, tx_line}, 32'd0);

      // R2: mixed fields, no update yet, toggle stays 0 (R4)
      send(1'b0, 5'd5, 11'b1_0_1_0_1_0_1_0011, 1'b0, "R2");
      wait_done();
      // R4: one update before the strobe flips the toggle
      pulse_update();
      send(1'b0, 5'd17, 11'b0_1_0_1_0_1_0_1010, 1'b0, "R2");
      wait_done();
      // R4: two updates still flip it only once
      pulse_update();
      pulse_update();
      send(1'b0, 5'd9, 11'b0_0_1_1_0_0_1_0110, 1'b0, "R2");
      wait_done();
      // R4: no update keeps the toggle
      send(1'b0, 5'd9, 11'b0_0_1_1_0_0_1_0110, 1'b0, "R2");
      wait_done();
      // R4: update in the strobe cycle itself counts
      send(1'b0, 5'd1, 11'b0_0_0_0_0_0_0_0001, 1'b1, "R2");
      wait_done();
      // R3: lost link overrides every field
      send(1'b1, 5'd3, 11'b0_1_1_0_0_1_1_0111, 1'b0, "R3");
      wait_done();
      // R2 boundaries: all ones, card 15, level 31; then all zeros
      send(1'b0, 5'd31, 11'b1_1_1_1_1_1_1_1111, 1'b0, "R2");
      wait_done();
      send(1'b0, 5'd0, 11'b0_0_0_0_0_0_0_0000, 1'b0, "R2");
      wait_done();

      // R8 / R9: change inputs and strobe during a frame, with an update pulse
      send(1'b0, 5'd12, 11'b1_0_0_1_1_0_0_1001, 1'b0, "R8");
      repeat (40) @(negedge clk);
      set_fields(1'b1, 5'd30, 11'b0_1_1_0_0_1_1_0110);
      frame_start = 1'b1;
      level_update = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      level_update = 1'b0;
      pend = 1'b1;
      wait_done();
      begin
         int highs = 0;
         for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (tx_line) highs++;
         end
         check(highs == 0, "R9", highs, 0);
      end
      // R9: the ignored-window update still flips the next toggle
      send(1'b0, 5'd7, 11'b0_0_0_1_0_1_0_1100, 1'b0, "R9");
      wait_done();

      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R9", exp_q.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule